// File: doc/BRIEF.md
# Transmitter Failsafe and Loop-Test Monitor

This block sits beside the transmitter of a serial-bus remote terminal and judges the health of each reply the terminal sends. Two checks run during every message. A failsafe timer counts how many cycles the transmitter has been enabled without a break. If that run reaches the limit, the timer trips and the block holds the transmitter off for the rest of the message. An echo checker takes each word the receiver hears back from the terminal's own transmission. It flags the echo when its bit pattern differs from the word last sent, or when the receiver marks it invalid.

The results are collected per message. They reach the active-low `fail_n` output only when a message ends, and only when that message was not a broadcast. A broadcast message leaves `fail_n` as it was. The host reads `fail_n` as a self-test verdict, or feeds it back into the terminal's status flag.

The controller has three states:
- `ST_IDLE`: no message in progress.
- `ST_MSG`: a message is in progress and the transmitter may be enabled.
- `ST_LOCK`: the timer has tripped and the transmitter is forced off.

Its transitions:
- `msg_start` moves any state to `ST_MSG`.
- `msg_end` moves `ST_MSG` or `ST_LOCK` to `ST_IDLE`.
- A timer expiry in `ST_MSG` moves to `ST_LOCK`.
- `msg_start` takes priority over `msg_end`.

Top module: `tx_guard_top`

## Requirements
- R1: After reset `fail_n` is 1, and `tx_en_out` is 0 while `tx_en_in` is 0.
- R2: Outside `ST_LOCK`, `tx_en_out` equals `tx_en_in`.
- R3: During a message, once `tx_en_in` has been 1 for `TIMEOUT_CYC` consecutive cycles, `tx_en_out` is 0 from the next cycle until the message ends. A timed-out non-broadcast message drives `fail_n` to 0.
- R4: The failsafe count returns to zero on any cycle with `tx_en_in` at 0. Runs shorter than `TIMEOUT_CYC` cycles never trip it, even back to back.
- R5: An echo whose 16 bits differ in any position from the word last strobed by `tx_stb` marks the message as failed.
- R6: An echo presented with `rx_valid` at 0 marks the message as failed, even when its bits match.
- R7: On `msg_end` with `msg_bcast` at 0, `fail_n` becomes 0 if the message saw a timeout or an echo failure. Otherwise it becomes 1. The new value is visible in the cycle after `msg_end`.
- R8: On `msg_end` with `msg_bcast` at 1, `fail_n` keeps its previous value.
- R9: `fail_n` changes only in the cycle after a `msg_end`.
- R10: `msg_start` clears the per-message error record, so a clean message after a failed one drives `fail_n` back to 1.
- R11: After a message that ended in `ST_LOCK`, the next message lets `tx_en_in` through to `tx_en_out` again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| msg_start | input | 1 | One-cycle pulse at the start of a message |
| msg_end | input | 1 | One-cycle pulse at the end of a message |
| msg_bcast | input | 1 | Qualifies `msg_end`: the message was a broadcast |
| tx_en_in | input | 1 | Transmitter enable request |
| tx_en_out | output | 1 | Gated transmitter enable |
| tx_stb | input | 1 | Strobe for a transmitted word |
| tx_word | input | 16 | Transmitted word |
| rx_stb | input | 1 | Strobe for a received echo word |
| rx_valid | input | 1 | 1 when the echo word was received valid |
| rx_word | input | 16 | Received echo word |
| fail_n | output | 1 | Active-low fail verdict, updated at message end |

## Verification
The bench builds the block with `TIMEOUT_CYC` set to 24 instead of the default 38400 (768 µs at 50 MHz). This lets a single message hold the transmitter long enough to trip the timer and watch the lockout cycle by cycle. It also lets the bench place an enable run one cycle short of the limit on either side of a one-cycle drop. Word width stays at 16, so single-bit flips in random positions of random words exercise the full comparator.

// File: rtl/tx_guard_pkg.sv
package tx_guard_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MSG  = 2'd1,
        ST_LOCK = 2'd2
    } guard_state_t;

endpackage

// File: rtl/failsafe_timer.sv
module failsafe_timer #(
    parameter int TIMEOUT_CYC = 38400,
    localparam int CNT_W = $clog2(TIMEOUT_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic tx_en,
    output logic expire
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_CYC - 1);

    logic [CNT_W-1:0] cnt_q;

    assign expire = tx_en && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart || !tx_en) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R4: a break in the enable run empties the count
    a_r4_break_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> (cnt_q == '0));

    // R3: the count never runs past the limit
    a_r3_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

endmodule

// File: rtl/echo_checker.sv
module echo_checker #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_stb,
    input  logic [WORD_W-1:0] tx_word,
    input  logic              rx_stb,
    input  logic              rx_valid,
    input  logic [WORD_W-1:0] rx_word,
    output logic              loop_err
);

    logic [WORD_W-1:0] sent_q;
    logic              err_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sent_q <= '0;
            err_q  <= 1'b0;
        end else begin
            if (tx_stb) begin
                sent_q <= tx_word;
            end
            err_q <= rx_stb && (!rx_valid || (rx_word != sent_q));
        end
    end

    assign loop_err = err_q;

    // R6: an invalid echo is always reported
    a_r6_invalid_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_stb && !rx_valid) |=> loop_err);

    // R5: no report without an echo strobe
    a_r5_only_on_echo: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_stb |=> !loop_err);

endmodule

// File: rtl/guard_fsm.sv
module guard_fsm
    import tx_guard_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic msg_start,
    input  logic msg_end,
    input  logic msg_bcast,
    input  logic expire,
    input  logic loop_err,
    output logic lockout,
    output logic fail_n
);

    guard_state_t state_q, state_d;
    logic         tout_q, loop_q, fail_n_q;
    logic         trip;

    assign trip = (state_q == ST_MSG) && expire;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (msg_start) state_d = ST_MSG;
            end
            ST_MSG: begin
                if (msg_start)    state_d = ST_MSG;
                else if (msg_end) state_d = ST_IDLE;
                else if (expire)  state_d = ST_LOCK;
            end
            ST_LOCK: begin
                if (msg_start)    state_d = ST_MSG;
                else if (msg_end) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // per-message record and verdict
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tout_q   <= 1'b0;
            loop_q   <= 1'b0;
            fail_n_q <= 1'b1;
        end else if (msg_start) begin
            tout_q <= 1'b0;
            loop_q <= 1'b0;
        end else begin
            if (trip)     tout_q <= 1'b1;
            if (loop_err) loop_q <= 1'b1;
            if (msg_end && !msg_bcast) begin
                fail_n_q <= !(tout_q || loop_q || trip || loop_err);
            end
        end
    end

    // outputs
    always_comb begin
        lockout = (state_q == ST_LOCK);
        fail_n  = fail_n_q;
    end

    // R3: a trip inside a message locks the transmitter
    a_r3_trip_locks: assert property (@(posedge clk) disable iff (!rst_n)
        (trip && !msg_start && !msg_end) |=> lockout);

    // R11: a new message always leaves lockout
    a_r11_start_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
        msg_start |=> !lockout);

endmodule

// File: rtl/tx_guard_top.sv
module tx_guard_top #(
    parameter int WORD_W      = 16,
    parameter int TIMEOUT_CYC = 38400
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              msg_start,
    input  logic              msg_end,
    input  logic              msg_bcast,
    input  logic              tx_en_in,
    output logic              tx_en_out,
    input  logic              tx_stb,
    input  logic [WORD_W-1:0] tx_word,
    input  logic              rx_stb,
    input  logic              rx_valid,
    input  logic [WORD_W-1:0] rx_word,
    output logic              fail_n
);

    logic expire, loop_err, lockout;

    failsafe_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (msg_start),
        .tx_en   (tx_en_in),
        .expire  (expire)
    );

    echo_checker #(.WORD_W(WORD_W)) u_echo (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_stb   (tx_stb),
        .tx_word  (tx_word),
        .rx_stb   (rx_stb),
        .rx_valid (rx_valid),
        .rx_word  (rx_word),
        .loop_err (loop_err)
    );

    guard_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .msg_start (msg_start),
        .msg_end   (msg_end),
        .msg_bcast (msg_bcast),
        .expire    (expire),
        .loop_err  (loop_err),
        .lockout   (lockout),
        .fail_n    (fail_n)
    );

    assign tx_en_out = tx_en_in && !lockout;

    // R8: broadcast end keeps the verdict
    a_r8_bcast_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_end && msg_bcast) |=> $stable(fail_n));

    // R9: verdict moves only after a message end
    a_r9_end_only: assert property (@(posedge clk) disable iff (!rst_n)
        !msg_end |=> $stable(fail_n));

    // R7: an echo failure in a non-broadcast message drives the verdict low
    a_r7_err_reported: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_end && !msg_bcast && !msg_start && loop_err) |=> !fail_n);

endmodule

// File: tb/sim_tx_guard_top.sv
module sim_tx_guard_top;

    localparam int T = 24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        msg_start = 1'b0, msg_end = 1'b0, msg_bcast = 1'b0;
    logic        tx_en_in = 1'b0, tx_stb = 1'b0, rx_stb = 1'b0, rx_valid = 1'b0;
    logic [15:0] tx_word = '0, rx_word = '0;
    logic        tx_en_out, fail_n;

    int checks = 0;
    int errors = 0;
    logic exp_fail_n = 1'b1;

    always #10 clk = ~clk;

    tx_guard_top #(.WORD_W(16), .TIMEOUT_CYC(T)) u0 (
        .clk(clk), .rst_n(rst_n), .msg_start(msg_start), .msg_end(msg_end),
        .msg_bcast(msg_bcast), .tx_en_in(tx_en_in), .tx_en_out(tx_en_out),
        .tx_stb(tx_stb), .tx_word(tx_word), .rx_stb(rx_stb), .rx_valid(rx_valid),
        .rx_word(rx_word), .fail_n(fail_n)
    );

    task automatic check(input logic act, input logic expv, input string req);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b t=%0t", req, act, expv, $time);
        end
    endtask

    function automatic logic verdict(input logic prev, input bit bc, input bit bad);
        return bc ? prev : !bad;
    endfunction

    task automatic begin_msg();
        @(negedge clk) msg_start = 1'b1;
        @(negedge clk) msg_start = 1'b0;
    endtask

    task automatic end_msg(input bit bc, input bit bad, input string req);
        tx_en_in = 1'b0;
        @(negedge clk);
        @(negedge clk);
        #1 check(fail_n, exp_fail_n, "R9");
        msg_bcast = bc;
        msg_end = 1'b1;
        @(negedge clk) msg_end = 1'b0;
        msg_bcast = 1'b0;
        exp_fail_n = verdict(exp_fail_n, bc, bad);
        #1 check(fail_n, exp_fail_n, req);
    endtask

    task automatic run_msg(input int n, input bit bc, input int bad_idx,
                           input logic [15:0] flip, input bit inval, input string req);
        logic [15:0] w;
        bit bad = 0;
        begin_msg();
        tx_en_in = 1'b1;
        for (int i = 0; i < n; i++) begin
            w = 16'($urandom);
            tx_word = w;
            tx_stb = 1'b1;
            #1 check(tx_en_out, 1'b1, "R2");
            @(negedge clk) tx_stb = 1'b0;
            rx_stb = 1'b1;
            rx_valid = 1'b1;
            rx_word = w;
            if (i == bad_idx) begin
                rx_word = w ^ flip;
                rx_valid = !inval;
                if (flip != 16'h0 || inval) bad = 1;
            end
            @(negedge clk) rx_stb = 1'b0;
        end
        end_msg(bc, bad, req);
    endtask

    task automatic run_long(input bit bc);
        begin_msg();
        for (int i = 0; i < T + 5; i++) begin
            tx_en_in = 1'b1;
            #1 check(tx_en_out, (i < T) ? 1'b1 : 1'b0, "R3");
            @(negedge clk);
        end
        end_msg(bc, 1, "R3");
    endtask

    task automatic run_gap();
        begin_msg();
        for (int k = 0; k < 2; k++) begin
            for (int i = 0; i < T - 1; i++) begin
                tx_en_in = 1'b1;
                #1 check(tx_en_out, 1'b1, "R4");
                @(negedge clk);
            end
            tx_en_in = 1'b0;
            @(negedge clk);
        end
        end_msg(0, 0, "R4");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1553));
        repeat (3) @(negedge clk);
        #1 check(fail_n, 1'b1, "R1");
        check(tx_en_out, 1'b0, "R1");
        rst_n = 1'b1;
        @(negedge clk);

        run_msg(3, 0, -1, 16'h0, 0, "R7");
        run_msg(4, 0, 2, 16'h0100, 0, "R5");
        run_msg(2, 0, -1, 16'h0, 0, "R10");
        run_msg(3, 0, 1, 16'h0, 1, "R6");
        run_msg(3, 1, -1, 16'h0, 0, "R8");
        run_msg(2, 0, 0, 16'h8000, 0, "R5");
        run_msg(1, 0, -1, 16'h0, 0, "R10");
        run_msg(2, 1, 0, 16'h0001, 0, "R8");
        run_long(0);
        begin_msg();
        tx_en_in = 1'b1;
        #1 check(tx_en_out, 1'b1, "R11");
        end_msg(0, 0, "R11");
        run_gap();
        run_long(1);

        for (int m = 0; m < 60; m++) begin
            int n    = 1 + int'($urandom_range(4));
            bit bc   = ($urandom_range(3) == 0);
            int kind = int'($urandom_range(3));
            int idx  = int'($urandom_range(n - 1));
            logic [15:0] fl = 16'(1) << $urandom_range(15);
            if (kind == 0)      run_msg(n, bc, idx, fl, 0, "R5");
            else if (kind == 1) run_msg(n, bc, idx, 16'h0, 1, "R6");
            else                run_msg(n, bc, -1, 16'h0, 0, bc ? "R8" : "R7");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule